// File: doc/BRIEF.md
# Sequential LFSR-Search AES Substitution Box

This block computes the AES substitution of one byte. The multiplicative inverse comes from a search, not from a lookup table or composite-field arithmetic. The input byte belongs to the AES field, GF(2^8) reduced by x^8+x^4+x^3+x+1. An isomorphism first maps it into the field reduced by the primitive polynomial x^8+x^4+x^3+x^2+1. In that field the element x generates every nonzero value.

Two identical 8-bit shift-register generators are seeded with 0x01 and stepped together:
- one multiplies its state by x on each step;
- the other multiplies its state by x^-1 on each step.

After i steps the two states are x^i and x^-i, so each one is the inverse of the other. When either state equals the mapped input, the other state is the inverse. Because the two registers run in opposite directions, 128 steps cover all 255 nonzero elements.

The found inverse is mapped back into the AES field, and the affine transform is applied to give the output. The user pulses a start strobe with a byte. After a variable latency of 1 to 128 cycles, a one-cycle done strobe arrives with the substituted byte. Only one byte is processed at a time.

Top module: `lfsr_inv_sbox`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is 0 and `dout_o` is 0x00 until the first operation completes.
- R2: For every input byte, the `dout_o` value shown with `done_o` equals the AES S-box value. That value is the inverse in GF(2^8) mod x^8+x^4+x^3+x+1 (zero maps to zero), followed by the affine transform y = b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63, where rotl rotates left within the byte.
- R3: Input 0x00 skips the search. It produces 0x63 with `done_o` high exactly 1 cycle after the edge that accepts the start.
- R4: Input 0x01 maps to the common seed and matches at step 0. It produces 0x7C with `done_o` high exactly 1 cycle after the accepting edge.
- R5: `done_o` rises no more than 128 cycles after the accepting edge. At least one input needs exactly 128 cycles, and the internal step count never exceeds 127.
- R6: `done_o` is a single-cycle pulse.
- R7: A start received while an operation is in flight is ignored. The running operation still returns the result for its own input, and it produces exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when idle |
| din_i | input | 8 | Byte to substitute, sampled with an accepted start |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| dout_o | output | 8 | Substituted byte; holds its value until the next result |

## Verification
The assertions assume two things about the input:
- `din_i` matters only in the cycle where a start is accepted;
- a start that arrives during a search is legal stimulus and must leave the search untouched.

They also assume that the constant-function isomorphism correctly maps the seed 0x01 to itself. Without that, the step-0 match for input 0x01 would not exist.

The bench keeps within these assumptions:
- it raises start for a single cycle from the idle state;
- it waits for done before launching the next byte;
- it injects a deliberate extra start only in the cycle right after an acceptance, when the block is certain to be busy.

It sweeps all 256 byte values against a table computed arithmetically in the bench.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic {STEP_UP, STEP_DOWN} dir_e;

   // multiply in GF(2^8) reduced by x^8 + red
   function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] b,
                                                input logic [BYTE_W-1:0] red);
      logic [BYTE_W-1:0] acc;
      logic [BYTE_W-1:0] sh;
      acc = '0;
      sh  = a;
      for (int k = 0; k < BYTE_W; k++) begin
         if (b[k]) acc = acc ^ sh;
         sh = sh[BYTE_W-1] ? ((sh << 1) ^ red) : (sh << 1);
      end
      return acc;
   endfunction

   // first element of the dst field that is a root of x^8 + src_red
   function automatic logic [BYTE_W-1:0] find_root(input logic [BYTE_W-1:0] src_red,
                                                   input logic [BYTE_W-1:0] dst_red);
      logic [BYTE_W-1:0] res;
      logic [BYTE_W-1:0] pw;
      logic [BYTE_W-1:0] acc;
      res = '0;
      for (int c = 2; c < 256; c++) begin
         pw  = 8'h01;
         acc = '0;
         for (int j = 0; j < BYTE_W; j++) begin
            if (src_red[j]) acc = acc ^ pw;
            pw = gf_mul(pw, BYTE_W'(c), dst_red);
         end
         acc = acc ^ pw;
         if (acc == '0 && res == '0) res = BYTE_W'(c);
      end
      return res;
   endfunction

   // linear map whose column j is root^j
   function automatic logic [BYTE_W*BYTE_W-1:0] basis_matrix(input logic [BYTE_W-1:0] root,
                                                             input logic [BYTE_W-1:0] dst_red);
      logic [BYTE_W*BYTE_W-1:0] m;
      logic [BYTE_W-1:0]        pw;
      pw = 8'h01;
      m  = '0;
      for (int j = 0; j < BYTE_W; j++) begin
         m[j*BYTE_W +: BYTE_W] = pw;
         pw = gf_mul(pw, root, dst_red);
      end
      return m;
   endfunction

   function automatic logic [BYTE_W-1:0] mat_apply(input logic [BYTE_W*BYTE_W-1:0] m,
                                                   input logic [BYTE_W-1:0] v);
      logic [BYTE_W-1:0] r;
      r = '0;
      for (int j = 0; j < BYTE_W; j++)
         if (v[j]) r = r ^ m[j*BYTE_W +: BYTE_W];
      return r;
   endfunction

   // invert a bijective map by locating each unit vector's preimage
   function automatic logic [BYTE_W*BYTE_W-1:0] invert_matrix(input logic [BYTE_W*BYTE_W-1:0] m);
      logic [BYTE_W*BYTE_W-1:0] r;
      r = '0;
      for (int j = 0; j < BYTE_W; j++)
         for (int a = 1; a < 256; a++)
            if (mat_apply(m, BYTE_W'(a)) == (BYTE_W'(1) << j))
               r[j*BYTE_W +: BYTE_W] = BYTE_W'(a);
      return r;
   endfunction
endpackage

// File: rtl/sbx_lfsr.sv
module sbx_lfsr
   import sbx_pkg::*;
#(
   parameter logic [BYTE_W-1:0] POLY = 8'h1D,
   parameter dir_e              DIR  = STEP_UP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [BYTE_W-1:0] state
);
   localparam logic [BYTE_W-1:0] SEED = 8'h01;

   logic [BYTE_W-1:0] nxt;

   generate
      if (DIR == STEP_UP) begin : g_up
         // multiply by x
         always_comb nxt = state[BYTE_W-1] ? ((state << 1) ^ POLY) : (state << 1);
      end else begin : g_down
         // multiply by x^-1
         always_comb nxt = state[0] ? (((state ^ POLY) >> 1) | {1'b1, {(BYTE_W-1){1'b0}}})
                                    : (state >> 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     state <= SEED;
      else if (load)  state <= SEED;
      else if (step)  state <= nxt;
   end

   // R5
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) state != '0);
endmodule

// File: rtl/sbx_map_in.sv
module sbx_map_in
   import sbx_pkg::*;
#(
   parameter logic [BYTE_W*BYTE_W-1:0] MAT = '0
) (
   input  logic [BYTE_W-1:0] a,
   output logic [BYTE_W-1:0] b
);
   always_comb b = mat_apply(MAT, a);
endmodule

// File: rtl/sbx_map_out.sv
module sbx_map_out
   import sbx_pkg::*;
#(
   parameter logic [BYTE_W*BYTE_W-1:0] MAT     = '0,
   parameter logic [BYTE_W-1:0]        AFF_C   = 8'h63,
   parameter int                       AFF_ROT = 4
) (
   input  logic [BYTE_W-1:0] inv,
   output logic [BYTE_W-1:0] sub
);
   logic [BYTE_W-1:0] back;
   logic [BYTE_W-1:0] rot [AFF_ROT+1];

   always_comb back = mat_apply(MAT, inv);
   assign rot[0] = back;

   genvar k;
   generate
      for (k = 1; k <= AFF_ROT; k++) begin : g_rot
         assign rot[k] = {rot[k-1][BYTE_W-2:0], rot[k-1][BYTE_W-1]};
      end
   endgenerate

   always_comb begin
      sub = AFF_C;
      for (int k2 = 0; k2 <= AFF_ROT; k2++) sub = sub ^ rot[k2];
   end
endmodule

// File: rtl/lfsr_inv_sbox.sv
module lfsr_inv_sbox
   import sbx_pkg::*;
#(
   parameter logic [BYTE_W-1:0] AES_RED  = 8'h1B,
   parameter logic [BYTE_W-1:0] LFSR_RED = 8'h1D,
   parameter logic [BYTE_W-1:0] AFF_C    = 8'h63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [BYTE_W-1:0] din_i,
   output logic              done_o,
   output logic [BYTE_W-1:0] dout_o
);
   localparam int MAX_STEPS = ((1 << BYTE_W) - 1) / 2;
   localparam int STEP_W    = $clog2(MAX_STEPS + 1) + 1;
   localparam logic [BYTE_W-1:0]        ROOT    = find_root(AES_RED, LFSR_RED);
   localparam logic [BYTE_W*BYTE_W-1:0] MAT_IN  = basis_matrix(ROOT, LFSR_RED);
   localparam logic [BYTE_W*BYTE_W-1:0] MAT_OUT = invert_matrix(MAT_IN);

   generate
      if (ROOT == '0) begin : g_bad_poly
         $error("lfsr_inv_sbox: AES_RED has no root in the LFSR field");
      end
      if (BYTE_W != 8) begin : g_bad_width
         $error("lfsr_inv_sbox: byte width must be 8");
      end
   endgenerate

   logic              busy_q, zero_q, done_q;
   logic [BYTE_W-1:0] tgt_q, dout_q, mapped, fwd, bwd, inv_sel, sub;
   logic [STEP_W-1:0] cnt_q;
   logic              accept, hit_f, hit_b, hit;

   assign accept = start_i && !busy_q;
   assign hit_f  = (tgt_q == fwd);
   assign hit_b  = (tgt_q == bwd);
   assign hit    = zero_q || hit_f || hit_b;
   assign inv_sel = zero_q ? '0 : (hit_f ? bwd : fwd);

   sbx_map_in #(.MAT(MAT_IN)) u_map_in (.a(din_i), .b(mapped));

   sbx_lfsr #(.POLY(LFSR_RED), .DIR(STEP_UP)) u_fwd (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(busy_q && !hit), .state(fwd));

   sbx_lfsr #(.POLY(LFSR_RED), .DIR(STEP_DOWN)) u_bwd (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(busy_q && !hit), .state(bwd));

   sbx_map_out #(.MAT(MAT_OUT), .AFF_C(AFF_C)) u_map_out (.inv(inv_sel), .sub(sub));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         zero_q <= 1'b0;
         done_q <= 1'b0;
         tgt_q  <= '0;
         dout_q <= '0;
         cnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            zero_q <= (din_i == '0);
            tgt_q  <= mapped;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (hit) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               dout_q <= sub;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign dout_o = dout_q;

   // R5
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> cnt_q <= STEP_W'(MAX_STEPS));
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i) |=> $stable(tgt_q) && (busy_q || done_o));
   // R3
   zero_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && din_i == '0) |=> ##1 (done_o && dout_o == 8'h63));
   // R4
   one_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && din_i == 8'h01) |=> ##1 (done_o && dout_o == 8'h7C));
endmodule

// File: tb/lfsr_inv_sbox_bench.sv
module lfsr_inv_sbox_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] din_i = '0;
   logic       done_o;
   logic [7:0] dout_o;

   int n_chk = 0;
   int n_bad = 0;
   int max_lat = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   lfsr_inv_sbox u_lfsr_inv_sbox (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .din_i(din_i),
      .done_o(done_o), .dout_o(dout_o));

   function automatic logic [7:0] aes_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r = '0;
      logic [7:0] s = a;
      for (int k = 0; k < 8; k++) begin
         if (b[k]) r ^= s;
         s = s[7] ? ((s << 1) ^ 8'h1B) : (s << 1);
      end
      return r;
   endfunction

   function automatic logic [7:0] ref_sbox(input logic [7:0] a);
      logic [7:0] inv = '0;
      logic [7:0] y;
      for (int c = 1; c < 256; c++)
         if (aes_mul(a, 8'(c)) == 8'h01) inv = 8'(c);
      y = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
          ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      return y;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // start one byte, optionally inject a stray start while busy; returns result and latency
   task automatic run(input logic [7:0] a, input bit stray, output logic [7:0] res,
                      output int lat, output int extra);
      @(negedge clk);
      start_i = 1'b1;
      din_i   = a;
      @(negedge clk);
      start_i = stray;
      din_i   = stray ? ~a : 8'h00;
      lat   = 0;
      extra = 0;
      forever begin
         @(negedge clk);
         start_i = 1'b0;
         lat++;
         if (done_o) break;
         if (lat > 300) break;
      end
      res = dout_o;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (done_o) extra++;
      end
   endtask

   initial begin
      logic [7:0] res;
      int lat, extra;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(done_o == 1'b0, "R1 done in reset", done_o, 0);
      check(dout_o == 8'h00, "R1 dout in reset", dout_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done_o == 1'b0, "R1 done after reset", done_o, 0);
      check(dout_o == 8'h00, "R1 dout after reset", dout_o, 0);

      // R3 zero input
      run(8'h00, 1'b0, res, lat, extra);
      check(res == 8'h63, "R3 zero result", res, 8'h63);
      check(lat == 1, "R3 zero latency", lat, 1);

      // R4 seed-matching input
      run(8'h01, 1'b0, res, lat, extra);
      check(res == 8'h7C, "R4 one result", res, 8'h7C);
      check(lat == 1, "R4 one latency", lat, 1);

      // R2 R5 R6 full sweep
      for (int a = 0; a < 256; a++) begin
         run(8'(a), 1'b0, res, lat, extra);
         check(res == ref_sbox(8'(a)), "R2 sbox value", res, ref_sbox(8'(a)));
         check(lat >= 1 && lat <= 128, "R5 latency bound", lat, 128);
         check(extra == 0, "R6 single pulse", extra, 0);
         if (lat > max_lat) max_lat = lat;
      end
      check(max_lat == 128, "R5 worst latency reached", max_lat, 128);

      // R7 stray start while busy
      for (int a = 2; a < 256; a += 37) begin
         run(8'(a), 1'b1, res, lat, extra);
         check(res == ref_sbox(8'(a)), "R7 result kept", res, ref_sbox(8'(a)));
         check(extra == 0, "R7 no extra done", extra, 0);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule